// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked control front end of a single-ported burst SRAM with a shared data bus and four byte lanes. It samples every control input on the rising clock edge and decides four things: whether a new access begins, whether the cycle reads or writes, which byte lanes are written, and whether the read data may be driven onto the bus. A small internal word array stands in for the memory core, so every decision can be observed at the ports.

An access can be opened by either of two address strobes. The processor strobe opens an access and leaves the read/write decision to the next edge. The controller strobe decides read or write in the same edge that opens the access. After an access is open, cycles without a strobe continue the burst. A two-bit burst counter then supplies the low address bits, in either linear or interleaved order.

The state machine has four states. `S_IDLE` means no access is open. `S_PSTART` means a processor strobe has opened an access. `S_READ` means the last access was a read. `S_WRITE` means the last access was a write. Every state moves to `S_PSTART` on a processor start (transition *pstart*). A controller start moves to `S_READ` or `S_WRITE` (transition *cstart*). A strobe seen while the chip is deselected moves to `S_IDLE` (transition *deselect*). Without a strobe, the three open states move to `S_READ` or `S_WRITE` according to the write inputs (transition *continue*). `S_IDLE` holds when no strobe is seen (transition *hold*).

Top module: `sburst_ctrl`

## Requirements
- R1: An access starts only at an edge where `sel0_n`=0, `sel1`=1 and `sel2_n`=0 and an address strobe is low. If a strobe is low while the chip is not selected, the open burst ends: the machine goes idle, and later strobe-free cycles neither write nor change `dq_out`.
- R2: While `sel0_n`=1, the processor strobe `pstb_n` is ignored completely. A strobe-free cycle then continues the open burst as if `pstb_n` were high.
- R3: When both strobes are low and the chip is selected, the processor strobe wins. The controller strobe and the write inputs are ignored at that edge, and nothing is written.
- R4: A processor start loads `addr`, writes nothing and reads that word into `dq_out`. At the next edge with no strobe, active write inputs write to the loaded word (when `adv_n`=1).
- R5: A controller start loads `addr` and samples the write inputs at the same edge. If they signal a write, the word at `addr` is written at that edge. Otherwise the word at `addr` appears on `dq_out` after the edge.
- R6: A write is signalled when `gwr_n`=0, or when `bwr_n`=0 and some bit of `bsel_n` is 0. `gwr_n`=0 enables all four lanes. Otherwise bit k of `bsel_n`=0 enables lane k, which is `wdata`/`dq_out` bits 8k+7..8k. `lane_we` bit k=1 marks lane k written at this edge.
- R7: While the write inputs signal a write, `dq_oe` is 0 whatever `oe_n` is.
- R8: `dq_oe` is 1 only when the last access was a read (states `S_PSTART`/`S_READ`) and `oe_n`=0. `dq_out` holds the word read at the last read edge.
- R9: At a strobe-free edge with an open burst, `adv_n`=0 steps the two-bit counter before the access. The low address bits are base+count (mod 4) when `ilv`=0, and base XOR count when `ilv`=1. The upper bits stay as loaded, and the sequence wraps after four steps.
- R10: During reset and just after it, the machine is idle, `dq_oe`=0, `dq_out`=0, `lane_we`=0, and every array word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_n | input | 1 | Chip select 0, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select 1, active high |
| sel2_n | input | 1 | Chip select 2, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data, four 8-bit lanes |
| dq_out | output | 32 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |
| lane_we | output | 4 | Lane write strobes for this edge |

## Verification
The hardest case to reach is an open burst that meets strobes it must ignore. One example is a processor strobe with `sel0_n` high arriving in the middle of a burst. Another is both strobes falling together with the write inputs active. Random traffic hits these rarely, because it usually starts a new access or deselects first. Directed sequences therefore build a burst over a known preloaded pattern, inject the ignored strobe, and check that the next word of the burst comes out. A long seeded random run is then checked against a bench model of the state, the counter and the array.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PSTART = 2'd1,
        S_READ   = 2'd2,
        S_WRITE  = 2'd3
    } sbc_state_e;
endpackage

// File: rtl/sbc_burst_gen.sv
module sbc_burst_gen #(
    parameter int AW = 4,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          adv,
    input  logic          ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] cnt_eff;
    logic [BB-1:0] low;

    // counter value used by this edge's access (advance happens first)
    assign cnt_eff = adv ? BB'(cnt_q + 1'b1) : cnt_q;

    generate
        if (BB > 0) begin : g_low
            assign low = ilv ? (base_q[BB-1:0] ^ cnt_eff)
                             : BB'(base_q[BB-1:0] + cnt_eff);
        end
    endgenerate

    assign addr_out = {base_q[AW-1:BB], low};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_eff;
        end
    end

    // R9: each advancing continuation moves the counter by one, wrapping
    p_wrap_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv && !load) |=> (cnt_q == BB'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/sbc_access_fsm.sv
module sbc_access_fsm
    import sbc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] bsel_n,
    output logic             load,
    output logic             step,
    output logic             rd_acc,
    output logic [LANES-1:0] lane_we,
    output logic             rd_side,
    output logic             wr_seen
);
    sbc_state_e state_q, state_d;
    logic selected, p_live, p_start, c_start, desel;
    logic [LANES-1:0] lanes;

    assign selected = !sel0_n && sel1 && !sel2_n;
    assign p_live   = !pstb_n && !sel0_n;
    assign p_start  = selected && p_live;
    assign c_start  = selected && !p_live && !cstb_n;
    assign desel    = !selected && (p_live || !cstb_n);
    assign lanes    = !gwr_n ? '1 : (!bwr_n ? ~bsel_n : '0);
    assign wr_seen  = |lanes;
    assign rd_side  = (state_q == S_PSTART) || (state_q == S_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        rd_acc  = 1'b0;
        lane_we = '0;
        if (p_start) begin
            state_d = S_PSTART;
            load    = 1'b1;
            rd_acc  = 1'b1;
        end else if (c_start) begin
            load = 1'b1;
            if (wr_seen) begin
                state_d = S_WRITE;
                lane_we = lanes;
            end else begin
                state_d = S_READ;
                rd_acc  = 1'b1;
            end
        end else if (desel) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_PSTART, S_READ, S_WRITE: begin
                    step = 1'b1;
                    if (wr_seen) begin
                        state_d = S_WRITE;
                        lane_we = lanes;
                    end else begin
                        state_d = S_READ;
                        rd_acc  = 1'b1;
                    end
                end
            endcase
        end
    end

    // R1: an address load needs all three selects active
    p_load_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!sel0_n && sel1 && !sel2_n));
    // R4: the opening edge of a processor access writes nothing
    p_pstart_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !sel0_n && sel1 && !sel2_n) |-> (lane_we == '0));
    // R6: global write drives every lane
    p_global_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gwr_n && lane_we != '0) |-> (lane_we == '1));
    // R1: a deselected strobe leaves the machine idle
    p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!sel0_n && sel1 && !sel2_n) && !cstb_n) |=> (state_q == S_IDLE));
endmodule

// File: rtl/sbc_lane_array.sv
module sbc_lane_array #(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    lane_we,
    input  logic [LANES*LW-1:0] wdata,
    input  logic                rd_en,
    output logic [LANES*LW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (rd_en) rdata_q <= mem[addr];
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) mem[addr][l*LW +: LW] <= wdata[l*LW +: LW];
            end
        end
    end

    // R5: reads and writes never share an edge
    p_rw_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && lane_we != '0));
endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl #(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic                pstb_n,
    input  logic                cstb_n,
    input  logic                adv_n,
    input  logic                gwr_n,
    input  logic                bwr_n,
    input  logic [LANES-1:0]    bsel_n,
    input  logic                ilv,
    input  logic                oe_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] dq_out,
    output logic                dq_oe,
    output logic [LANES-1:0]    lane_we
);
    localparam int DW = LANES * LW;
    localparam int BB = 2;

    logic load, step, rd_acc, rd_side, wr_seen;
    logic [AW-1:0] burst_addr, eff_addr;

    sbc_access_fsm #(.LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .bsel_n(bsel_n),
        .load(load), .step(step), .rd_acc(rd_acc),
        .lane_we(lane_we), .rd_side(rd_side), .wr_seen(wr_seen)
    );

    sbc_burst_gen #(.AW(AW), .BB(BB)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .load(load), .step(step), .adv(!adv_n), .ilv(ilv),
        .addr_in(addr), .addr_out(burst_addr)
    );

    assign eff_addr = load ? addr : burst_addr;

    sbc_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .addr(eff_addr), .lane_we(lane_we), .wdata(wdata),
        .rd_en(rd_acc), .rdata_q(dq_out)
    );

    assign dq_oe = rd_side && !oe_n && !wr_seen;

    // R7: any lane write forces the bus off
    p_bus_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> !dq_oe);
    // R8: bus drive requires the output enable
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);
    // R8: read data register only moves after a read edge
    p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_acc) |=> $stable(dq_out));
endmodule

// File: tb/sburst_ctrl_test.sv
`timescale 1ns/1ps
module sburst_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel0_n, sel1, sel2_n, pstb_n, cstb_n, adv_n, gwr_n, bwr_n, ilv, oe_n;
    logic [3:0]  bsel_n;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic [3:0]  lane_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_mem [16];
    logic        m_active, m_rdside;
    logic [3:0]  m_base;
    logic [1:0]  m_cnt;
    logic [31:0] m_dq;

    always #4 clk = ~clk;

    sburst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n),
        .bwr_n(bwr_n), .bsel_n(bsel_n), .ilv(ilv), .oe_n(oe_n), .addr(addr),
        .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe), .lane_we(lane_we)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0101_0101;
    endfunction

    function automatic logic [1:0] low_of(logic il, logic [1:0] b, logic [1:0] c);
        return il ? (b ^ c) : 2'(b + c);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic quiet();
        sel0_n = 0; sel1 = 1; sel2_n = 0; pstb_n = 1; cstb_n = 1; adv_n = 1;
        gwr_n = 1; bwr_n = 1; bsel_n = 4'hF; oe_n = 0; addr = 0; wdata = 0;
    endtask

    // one clock: check comb outputs, update model, check registered data
    task automatic cycle(string tag);
        logic sel, pl, sp, sc, ds, wq, ct;
        logic [3:0] ln, ea;
        logic [1:0] ce;
        #1;
        sel = !sel0_n && sel1 && !sel2_n;
        pl  = !pstb_n && !sel0_n;
        sp  = sel && pl;
        sc  = sel && !pl && !cstb_n;
        ds  = !sel && (pl || !cstb_n);
        ln  = !gwr_n ? 4'hF : (!bwr_n ? ~bsel_n : 4'h0);
        wq  = (ln != 0);
        ct  = !sp && !sc && !ds && m_active;
        chk({tag, " lane strobes R6"}, 32'(lane_we), ((sc || ct) && wq) ? 32'(ln) : 32'h0);
        chk({tag, " bus enable R7 R8"}, 32'(dq_oe), 32'(m_rdside && !oe_n && !wq));
        ea = addr;
        if (sp) begin
            m_base = addr; m_cnt = 0; m_active = 1; m_rdside = 1; m_dq = m_mem[addr];
        end else if (sc) begin
            m_base = addr; m_cnt = 0; m_active = 1; m_rdside = !wq;
        end else if (ds) begin
            m_active = 0; m_rdside = 0;
        end else if (ct) begin
            ce = adv_n ? m_cnt : 2'(m_cnt + 1);
            m_cnt = ce;
            ea = {m_base[3:2], low_of(ilv, m_base[1:0], ce)};
            m_rdside = !wq;
        end
        if ((sc || ct) && wq) begin
            for (int j = 0; j < 4; j++)
                if (ln[j]) m_mem[ea][j*8 +: 8] = wdata[j*8 +: 8];
        end else if (sc || ct) begin
            m_dq = m_mem[ea];
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " read data R5"}, dq_out, m_dq);
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog R10 actual=%h expected=%h", 32'h0, 32'h1);
        summary();
    end

    initial begin
        quiet(); ilv = 0;
        for (int i = 0; i < 16; i++) m_mem[i] = 0;
        m_active = 0; m_rdside = 0; m_base = 0; m_cnt = 0; m_dq = 0;
        repeat (3) @(negedge clk);
        chk("reset R10 dq_oe", 32'(dq_oe), 0);
        chk("reset R10 dq_out", dq_out, 0);
        chk("reset R10 lane_we", 32'(lane_we), 0);
        rst_n = 1;
        @(negedge clk);
        // reset array content visible through a read
        quiet(); cstb_n = 0; addr = 4'd11; cycle("R10 array");
        chk("R10 array zero", dq_out, 0);

        // preload through controller writes (R5)
        for (int i = 0; i < 16; i++) begin
            quiet(); cstb_n = 0; gwr_n = 0; addr = 4'(i); wdata = pat(i);
            cycle("R5 preload");
        end
        quiet(); cstb_n = 0; addr = 4'd9; cycle("R5 read");
        chk("R5 read 9", dq_out, pat(9));
        quiet(); #1; chk("R8 oe low drives", 32'(dq_oe), 1);
        oe_n = 1; #1; chk("R8 oe high off", 32'(dq_oe), 0);
        cycle("R8");

        // R9 linear from 5: 6,7,4,5
        quiet(); ilv = 0; cstb_n = 0; addr = 4'd5; cycle("R9 lin");
        quiet(); adv_n = 0; cycle("R9 lin"); chk("R9 lin step1", dq_out, pat(6));
        quiet(); adv_n = 0; cycle("R9 lin"); chk("R9 lin step2", dq_out, pat(7));
        quiet(); adv_n = 0; cycle("R9 lin"); chk("R9 lin step3", dq_out, pat(4));
        quiet(); adv_n = 0; cycle("R9 lin"); chk("R9 lin wrap", dq_out, pat(5));
        // R9 interleaved from 5: 4,7,6
        quiet(); ilv = 1; cstb_n = 0; addr = 4'd5; cycle("R9 ilv");
        quiet(); ilv = 1; adv_n = 0; cycle("R9 ilv"); chk("R9 ilv step1", dq_out, pat(4));
        quiet(); ilv = 1; adv_n = 0; cycle("R9 ilv"); chk("R9 ilv step2", dq_out, pat(7));
        quiet(); ilv = 1; adv_n = 0; cycle("R9 ilv"); chk("R9 ilv step3", dq_out, pat(6));
        ilv = 0;

        // R4 processor start: write inputs ignored at open, honoured next
        quiet(); pstb_n = 0; gwr_n = 0; addr = 4'd3; wdata = 32'h1111_1111;
        #1; chk("R4 open no write", 32'(lane_we), 0);
        cycle("R4 open"); chk("R4 open reads", dq_out, pat(3));
        quiet(); gwr_n = 0; wdata = 32'hFEED_BEEF; oe_n = 0;
        #1; chk("R4 second edge lanes", 32'(lane_we), 32'hF);
        chk("R7 write forces off", 32'(dq_oe), 0);
        cycle("R4 write");
        quiet(); cstb_n = 0; addr = 4'd3; cycle("R4 readback");
        chk("R4 readback", dq_out, 32'hFEED_BEEF);

        // R3 both strobes: processor wins, no write
        quiet(); pstb_n = 0; cstb_n = 0; gwr_n = 0; addr = 4'd10; wdata = 0;
        #1; chk("R3 no write", 32'(lane_we), 0);
        cycle("R3"); chk("R3 read", dq_out, pat(10));

        // R2 ignored processor strobe mid-burst
        quiet(); cstb_n = 0; addr = 4'd12; cycle("R2 open");
        quiet(); sel0_n = 1; pstb_n = 0; adv_n = 0; addr = 4'd0; cycle("R2");
        chk("R2 burst continues", dq_out, pat(13));

        // R1 deselect ends burst; no start without all selects
        quiet(); sel1 = 0; cstb_n = 0; cycle("R1 desel");
        quiet(); adv_n = 0; cycle("R1 idle"); chk("R1 idle holds", dq_out, pat(13));
        quiet(); #1; chk("R1 idle bus off", 32'(dq_oe), 0);
        sel2_n = 1; pstb_n = 0; addr = 4'd1; cycle("R1 no start");
        chk("R1 no start", dq_out, pat(13));

        // R6 byte lanes 0 and 2
        quiet(); cstb_n = 0; bwr_n = 0; bsel_n = 4'b1010; addr = 4'd8; wdata = 32'hAABB_CCDD;
        #1; chk("R6 lanes 0,2", 32'(lane_we), 32'h5);
        cycle("R6");
        quiet(); bwr_n = 1; bsel_n = 4'b0000; #1;
        chk("R6 selects need enable", 32'(lane_we), 0);
        cycle("R6");
        chk("R6 merged", dq_out, (pat(8) & 32'hFF00_FF00) | 32'h00BB_00DD);

        // constrained random with fixed seed
        void'($urandom(32'd4242));
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            sel0_n = (r[2:0] == 0); sel1 = (r[5:3] != 0); sel2_n = (r[8:6] == 0);
            pstb_n = (r[10:9] != 0); cstb_n = (r[12:11] != 0); adv_n = r[13];
            gwr_n = (r[16:14] != 0); bwr_n = r[17]; bsel_n = r[21:18];
            ilv = r[22]; oe_n = (r[24:23] == 0); addr = r[28:25];
            wdata = $urandom;
            cycle("random R1 R2 R3 R4 R9");
        end
        summary();
    end
endmodule